// File: doc/BRIEF.md
# Receive Free Buffer Pool Fetcher

This block supplies empty receive buffers to a frame reassembly engine. Software fills a circular table with pool entries. Each entry holds a buffer address together with three flags: valid, low-water (red-line) and wrap. The reassembly side asks for a buffer with a request/response handshake and marks whether the request is for the first buffer of a new frame. For each request, the block reads the table entry under its current index through a single-port read interface. It then answers with a grant carrying the buffer address, a discard, or a no-buffer response.

An entry whose valid flag is clear means the pool has run dry. The block records a sticky busy status, pulses an event output and stops fetching. Fetching resumes only after software writes the current-index register again. An entry carrying the red-line flag is still granted, but it also sets a sticky red-line status and pulses a second event output. Software can hold an early-discard control bit. While that bit is set, continuation buffers for frames already under way are still served, and every request opening a new frame is refused. Buffer sizing is the job of software that fills the table: every buffer except the last of a frame must hold a whole number of 48-octet cell payloads.

Top module: `rxpool_fetch`

## Requirements
- R1: A table entry on `mem_rd_data` is laid out as bit ADDR_W+2 = valid, bit ADDR_W+1 = red-line, bit ADDR_W = wrap, bits ADDR_W-1:0 = buffer address. A valid entry is answered with `rsp_code` 0 (grant) and its address on `rsp_addr`. Code 1 means discard and code 2 means no buffer.
- R2: At most one table read is in flight at a time. `mem_rd_data` is expected one cycle after `mem_rd_en`. A grant's `rsp_valid` pulse comes one cycle after that, so it is two cycles after `mem_rd_en`, and it lasts one cycle.
- R3: After a grant, the current index advances by one. After the last table entry (TBL_DEPTH-1), it returns to 0.
- R4: A granted entry with its wrap flag set sends the current index back to 0.
- R5: A granted entry with its red-line flag set is still granted. It also sets the sticky red-line status (control/status bit 5) and pulses `evt_redline` in the response cycle.
- R6: An entry with its valid flag clear gives a no-buffer response and sets sticky busy status (control/status bit 4). It also pulses `evt_busy` in the response cycle and leaves the current index unchanged.
- R7: After a busy fetch, every request is answered with no-buffer and no table read is issued. A software write to the index register (`sw_addr`=1) loads the index and re-enables fetching.
- R8: With early-discard (control/status bit 0) at 1, a request with `req_first`=1 is answered with discard and no table read is issued. A request with `req_first`=0 is still served from the table.
- R9: With early-discard at 0, first-buffer requests are granted normally.
- R10: After reset, busy, red-line, early-discard and the index are all 0, and no response or event is active. Unused bits of both software registers read as 0.
- R11: Writing 1 to bit 4 or bit 5 of the control/status register clears that sticky status bit. Writing 0 there leaves the bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Buffer request, held until `rsp_valid` |
| req_first | input | 1 | Request is for the first buffer of a frame |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 2 | 0 grant, 1 discard, 2 no buffer |
| rsp_addr | output | ADDR_W | Granted buffer address |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_idx | output | IDX_W | Table entry index to read |
| mem_rd_data | input | ADDR_W+3 | Entry read data, one cycle after the strobe |
| sw_wr_en | input | 1 | Software write strobe |
| sw_addr | input | 1 | 0 control/status, 1 current index |
| sw_wdata | input | 16 | Software write data |
| sw_rdata | output | 16 | Software read data for `sw_addr` |
| evt_busy | output | 1 | Pool-empty event pulse |
| evt_redline | output | 1 | Low-water event pulse |

## Verification
The bench builds the block with TBL_DEPTH=4 and ADDR_W=12. With four entries, the natural return from the last index to 0 is reached within a few grants, and a wrap-flagged entry in the middle of the table can be told apart from that natural wrap. The narrow address keeps the expected addresses readable in the vector table. The empty-pool stall, the re-arm through the index register, and early-discard with both first and continuation requests all fit in one short run.

// File: rtl/rxpool_pkg.sv
package rxpool_pkg;
  typedef enum logic [1:0] {
    RSP_GRANT   = 2'd0,
    RSP_DISCARD = 2'd1,
    RSP_NOBUF   = 2'd2
  } rsp_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } fetch_st_e;

  localparam int unsigned CSR_EPD_BIT  = 0;
  localparam int unsigned CSR_BUSY_BIT = 4;
  localparam int unsigned CSR_RLI_BIT  = 5;
  localparam int unsigned SW_DW        = 16;
endpackage

// File: rtl/rxpool_idx.sv
// Current-entry index and fetch-enable (armed) flag.
module rxpool_idx #(
  parameter int unsigned TBL_DEPTH = 16,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             advance,
  input  logic             wrap_hint,
  input  logic             stall_set,
  output logic [IDX_W-1:0] idx_o,
  output logic             armed_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TBL_DEPTH - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             armed_q, armed_d;
  logic             idx_en;

  always_comb begin
    idx_en = load | advance;
    if (load) begin
      idx_d = load_val;
    end else if (wrap_hint || (idx_q == LAST_IDX)) begin
      idx_d = '0;
    end else begin
      idx_d = idx_q + 1'b1;
    end
    if (load) begin
      armed_d = 1'b1;
    end else if (stall_set) begin
      armed_d = 1'b0;
    end else begin
      armed_d = armed_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (idx_en) idx_q <= idx_d;
      armed_q <= armed_d;
    end
  end

  assign idx_o   = idx_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/rxpool_regs.sv
// Software-visible control/status and index registers.
module rxpool_regs
  import rxpool_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic             sw_addr,
  input  logic [SW_DW-1:0] sw_wdata,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             set_busy,
  input  logic             set_rli,
  output logic             epd_o,
  output logic             busy_o,
  output logic             rli_o,
  output logic             idx_load_o,
  output logic [SW_DW-1:0] sw_rdata
);
  logic csr_wr;
  logic epd_q, epd_d;
  logic busy_q, busy_d;
  logic rli_q, rli_d;
  logic unused_wdata;

  assign unused_wdata = ^sw_wdata;

  always_comb begin
    csr_wr     = sw_wr_en & ~sw_addr;
    idx_load_o = sw_wr_en & sw_addr;
    epd_d      = epd_q;
    busy_d     = set_busy | (busy_q & ~(csr_wr & sw_wdata[CSR_BUSY_BIT]));
    rli_d      = set_rli  | (rli_q  & ~(csr_wr & sw_wdata[CSR_RLI_BIT]));
    if (csr_wr) epd_d = sw_wdata[CSR_EPD_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epd_q  <= 1'b0;
      busy_q <= 1'b0;
      rli_q  <= 1'b0;
    end else begin
      epd_q  <= epd_d;
      busy_q <= busy_d;
      rli_q  <= rli_d;
    end
  end

  always_comb begin
    sw_rdata = '0;
    if (!sw_addr) begin
      sw_rdata[CSR_EPD_BIT]  = epd_q;
      sw_rdata[CSR_BUSY_BIT] = busy_q;
      sw_rdata[CSR_RLI_BIT]  = rli_q;
    end else begin
      sw_rdata[IDX_W-1:0] = idx_i;
    end
  end

  assign epd_o  = epd_q;
  assign busy_o = busy_q;
  assign rli_o  = rli_q;
endmodule

// File: rtl/rxpool_ctrl.sv
// Request sequencing: discard / no-buffer / table fetch and response.
module rxpool_ctrl
  import rxpool_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  localparam int unsigned ENT_W = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_first,
  input  logic              epd,
  input  logic              armed,
  input  logic [ENT_W-1:0]  mem_rd_data,
  output logic              mem_rd_en,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              evt_busy,
  output logic              evt_redline,
  output logic              advance,
  output logic              wrap_hint,
  output logic              stall_set,
  output logic              set_busy,
  output logic              set_rli
);
  fetch_st_e         st_q, st_d;
  rsp_code_e         code_q, code_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              valid_q, busy_ev_q, rli_ev_q;
  logic              ld_rsp;
  logic              e_valid, e_rl;

  assign e_valid   = mem_rd_data[ADDR_W+2];
  assign e_rl      = mem_rd_data[ADDR_W+1];
  assign wrap_hint = mem_rd_data[ADDR_W];

  always_comb begin
    st_d      = st_q;
    mem_rd_en = 1'b0;
    ld_rsp    = 1'b0;
    code_d    = code_q;
    addr_d    = addr_q;
    advance   = 1'b0;
    stall_set = 1'b0;
    set_busy  = 1'b0;
    set_rli   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (epd && req_first) begin
            ld_rsp = 1'b1;
            code_d = RSP_DISCARD;
            st_d   = ST_DONE;
          end else if (!armed) begin
            ld_rsp = 1'b1;
            code_d = RSP_NOBUF;
            st_d   = ST_DONE;
          end else begin
            mem_rd_en = 1'b1;
            st_d      = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        ld_rsp = 1'b1;
        st_d   = ST_DONE;
        if (e_valid) begin
          code_d  = RSP_GRANT;
          addr_d  = mem_rd_data[ADDR_W-1:0];
          advance = 1'b1;
          set_rli = e_rl;
        end else begin
          code_d    = RSP_NOBUF;
          stall_set = 1'b1;
          set_busy  = 1'b1;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      valid_q   <= 1'b0;
      busy_ev_q <= 1'b0;
      rli_ev_q  <= 1'b0;
      code_q    <= RSP_GRANT;
      addr_q    <= '0;
    end else begin
      st_q      <= st_d;
      valid_q   <= ld_rsp;
      busy_ev_q <= set_busy;
      rli_ev_q  <= set_rli;
      if (ld_rsp) begin
        code_q <= code_d;
        addr_q <= addr_d;
      end
    end
  end

  assign rsp_valid   = valid_q;
  assign rsp_code    = code_q;
  assign rsp_addr    = addr_q;
  assign evt_busy    = busy_ev_q;
  assign evt_redline = rli_ev_q;
endmodule

// File: rtl/rxpool_fetch.sv
module rxpool_fetch
  import rxpool_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned TBL_DEPTH = 16,
  localparam int unsigned IDX_W    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1,
  localparam int unsigned ENT_W    = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_first,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              mem_rd_en,
  output logic [IDX_W-1:0]  mem_rd_idx,
  input  logic [ENT_W-1:0]  mem_rd_data,
  input  logic              sw_wr_en,
  input  logic              sw_addr,
  input  logic [15:0]       sw_wdata,
  output logic [15:0]       sw_rdata,
  output logic              evt_busy,
  output logic              evt_redline
);
  logic             sts_epd, sts_busy, sts_rli;
  logic             idx_load, pool_armed;
  logic             advance, wrap_hint, stall_set, set_busy, set_rli;
  logic [IDX_W-1:0] cur_idx;

  rxpool_regs #(.IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_wr_en   (sw_wr_en),
    .sw_addr    (sw_addr),
    .sw_wdata   (sw_wdata),
    .idx_i      (cur_idx),
    .set_busy   (set_busy),
    .set_rli    (set_rli),
    .epd_o      (sts_epd),
    .busy_o     (sts_busy),
    .rli_o      (sts_rli),
    .idx_load_o (idx_load),
    .sw_rdata   (sw_rdata)
  );

  rxpool_idx #(.TBL_DEPTH(TBL_DEPTH), .IDX_W(IDX_W)) u_idx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (idx_load),
    .load_val  (sw_wdata[IDX_W-1:0]),
    .advance   (advance),
    .wrap_hint (wrap_hint),
    .stall_set (stall_set),
    .idx_o     (cur_idx),
    .armed_o   (pool_armed)
  );

  rxpool_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_first   (req_first),
    .epd         (sts_epd),
    .armed       (pool_armed),
    .mem_rd_data (mem_rd_data),
    .mem_rd_en   (mem_rd_en),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code),
    .rsp_addr    (rsp_addr),
    .evt_busy    (evt_busy),
    .evt_redline (evt_redline),
    .advance     (advance),
    .wrap_hint   (wrap_hint),
    .stall_set   (stall_set),
    .set_busy    (set_busy),
    .set_rli     (set_rli)
  );

  assign mem_rd_idx = cur_idx;
endmodule

// File: rtl/rxpool_fetch_chk.sv
module rxpool_fetch_chk
  import rxpool_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_first,
  input logic       mem_rd_en,
  input logic       rsp_valid,
  input logic [1:0] rsp_code,
  input logic       evt_busy,
  input logic       evt_redline,
  input logic       sts_busy,
  input logic       sts_rli,
  input logic       sts_epd,
  input logic       pool_armed
);
  // R2: one read outstanding
  p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R2: grant two cycles after the read strobe
  p_grant_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RSP_GRANT) |-> $past(mem_rd_en, 2));

  // R2: response is a single-cycle strobe
  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5: red-line event only with a grant, and status follows
  p_redline_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_redline |-> (rsp_valid && rsp_code == RSP_GRANT && sts_rli));

  // R6: busy event only with a no-buffer response, and status follows
  p_busy_nobuf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_busy |-> (rsp_valid && rsp_code == RSP_NOBUF && sts_busy));

  // R7: no table read while stalled
  p_stall_noread_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pool_armed |-> !mem_rd_en);

  // R8: discard only for a first-buffer request under early discard
  p_epd_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RSP_DISCARD) |-> ($past(req_first) && $past(sts_epd)));
endmodule

bind rxpool_fetch rxpool_fetch_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_first   (req_first),
  .mem_rd_en   (mem_rd_en),
  .rsp_valid   (rsp_valid),
  .rsp_code    (rsp_code),
  .evt_busy    (evt_busy),
  .evt_redline (evt_redline),
  .sts_busy    (sts_busy),
  .sts_rli     (sts_rli),
  .sts_epd     (sts_epd),
  .pool_armed  (pool_armed)
);

// File: tb/rxpool_fetch_tb_top.sv
`timescale 1ns/1ps
module rxpool_fetch_tb_top;
  localparam int unsigned AW    = 12;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned IW    = 2;
  localparam int unsigned EW    = AW + 3;
  localparam int unsigned NVEC  = 7;

  // {first, epd, code[1:0], redline, addr[11:0], idx_after[1:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 2'd0, 1'b0, 12'h030, 2'd1},
    {1'b0, 1'b0, 2'd0, 1'b1, 12'h060, 2'd2},
    {1'b0, 1'b1, 2'd0, 1'b0, 12'h090, 2'd0},
    {1'b1, 1'b1, 2'd1, 1'b0, 12'h000, 2'd0},
    {1'b1, 1'b0, 2'd0, 1'b0, 12'h030, 2'd1},
    {1'b0, 1'b0, 2'd0, 1'b1, 12'h060, 2'd2},
    {1'b1, 1'b0, 2'd0, 1'b0, 12'h090, 2'd0}
  };

  logic          clk, rst_n;
  logic          req_valid, req_first;
  logic          rsp_valid;
  logic [1:0]    rsp_code;
  logic [AW-1:0] rsp_addr;
  logic          mem_rd_en;
  logic [IW-1:0] mem_rd_idx;
  logic [EW-1:0] mem_rd_data;
  logic          sw_wr_en, sw_addr;
  logic [15:0]   sw_wdata, sw_rdata;
  logic          evt_busy, evt_redline;

  logic [EW-1:0] tbl [DEPTH];
  int            n_chk, n_fail, n_reads;
  logic          done;

  rxpool_fetch #(.ADDR_W(AW), .TBL_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_first(req_first),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_addr(rsp_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_idx(mem_rd_idx), .mem_rd_data(mem_rd_data),
    .sw_wr_en(sw_wr_en), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .evt_busy(evt_busy), .evt_redline(evt_redline)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= tbl[mem_rd_idx];
      n_reads     <= n_reads + 1;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic sw_write(input logic a, input logic [15:0] d);
    @(negedge clk);
    sw_wr_en = 1'b1; sw_addr = a; sw_wdata = d;
    @(negedge clk);
    sw_wr_en = 1'b0;
  endtask

  task automatic sw_read(input logic a, output logic [15:0] d);
    @(negedge clk);
    sw_addr = a;
    #1 d = sw_rdata;
  endtask

  task automatic do_req(input logic first, output logic [1:0] code,
                        output logic [AW-1:0] addr, output logic eb, output logic er);
    bit got;
    got = 1'b0;
    code = 2'd3; addr = '0; eb = 1'b0; er = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_first = first;
    for (int k = 0; k < 10 && !got; k++) begin
      @(negedge clk);
      if (rsp_valid) begin
        got = 1'b1;
        code = rsp_code; addr = rsp_addr; eb = evt_busy; er = evt_redline;
        req_valid = 1'b0;
      end
    end
    if (!got) begin
      req_valid = 1'b0;
      check(1'b0, "R2 no response", 0, 1);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    finish_run();
  end

  initial begin
    logic [1:0]    c;
    logic [AW-1:0] a;
    logic          eb, er;
    logic [15:0]   rd;
    logic          cur_epd;
    int            r0;
    done = 1'b0; n_chk = 0; n_fail = 0; n_reads = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_first = 1'b0;
    sw_wr_en = 1'b0; sw_addr = 1'b0; sw_wdata = '0;
    mem_rd_data = '0;
    tbl[0] = {1'b1, 1'b0, 1'b0, 12'h030};
    tbl[1] = {1'b1, 1'b1, 1'b0, 12'h060};
    tbl[2] = {1'b1, 1'b0, 1'b1, 12'h090};
    tbl[3] = {1'b1, 1'b0, 1'b0, 12'h0C0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    @(negedge clk);
    check(!rsp_valid && !mem_rd_en && !evt_busy && !evt_redline, "R10 idle outputs",
          {rsp_valid, mem_rd_en, evt_busy, evt_redline}, 0);
    sw_read(1'b0, rd); check(rd == 16'h0000, "R10 csr reset", rd, 0);
    sw_read(1'b1, rd); check(rd == 16'h0000, "R10 index reset", rd, 0);

    // vector table: R1 R3 R4 R5 R8 R9
    cur_epd = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][17] != cur_epd) begin
        cur_epd = VEC[i][17];
        sw_write(1'b0, {15'd0, cur_epd});
      end
      r0 = n_reads;
      do_req(VEC[i][18], c, a, eb, er);
      check(c == VEC[i][16:15], $sformatf("R1/R8/R9 code vec%0d", i), c, VEC[i][16:15]);
      if (VEC[i][16:15] == 2'd0)
        check(a == VEC[i][13:2], $sformatf("R1 addr vec%0d", i), a, VEC[i][13:2]);
      else
        check(n_reads == r0, $sformatf("R8 no read on discard vec%0d", i), n_reads - r0, 0);
      check(er == VEC[i][14] && !eb, $sformatf("R5 events vec%0d", i), {eb, er}, {1'b0, VEC[i][14]});
      sw_read(1'b1, rd);
      check(rd == {14'd0, VEC[i][1:0]}, $sformatf("R3/R4 index vec%0d", i), rd, VEC[i][1:0]);
    end

    // R5 sticky red-line, R10 reserved bits, R11 write-0 keeps / write-1 clears
    sw_read(1'b0, rd); check(rd == 16'h0020, "R5 sticky redline", rd, 16'h0020);
    sw_write(1'b0, 16'h0000);
    sw_read(1'b0, rd); check(rd == 16'h0020, "R11 write 0 keeps", rd, 16'h0020);
    sw_write(1'b0, 16'h0020);
    sw_read(1'b0, rd); check(rd == 16'h0000, "R11 write 1 clears", rd, 0);

    // R3 natural wrap from last entry
    sw_write(1'b1, 16'h0003);
    do_req(1'b1, c, a, eb, er);
    check(c == 2'd0 && a == 12'h0C0, "R3 last entry grant", a, 12'h0C0);
    sw_read(1'b1, rd); check(rd == 16'h0000, "R3 wrap to base", rd, 0);

    // R6 empty pool
    tbl[0] = {1'b0, 1'b0, 1'b0, 12'h000};
    do_req(1'b1, c, a, eb, er);
    check(c == 2'd2, "R6 nobuf code", c, 2);
    check(eb && !er, "R6 busy event", {eb, er}, 2'b10);
    sw_read(1'b0, rd); check(rd == 16'h0010, "R6 sticky busy", rd, 16'h0010);
    sw_read(1'b1, rd); check(rd == 16'h0000, "R6 index held", rd, 0);

    // R7 stalled: no read, no new event
    r0 = n_reads;
    do_req(1'b0, c, a, eb, er);
    check(c == 2'd2 && !eb, "R7 stalled nobuf", {eb, c}, 2);
    check(n_reads == r0, "R7 no table read", n_reads - r0, 0);

    // R7 re-arm by index write
    sw_write(1'b1, 16'h0001);
    do_req(1'b1, c, a, eb, er);
    check(c == 2'd0 && a == 12'h060, "R7 rearmed grant", a, 12'h060);
    sw_read(1'b0, rd); check(rd == 16'h0030, "R11 both sticky set", rd, 16'h0030);
    sw_write(1'b0, 16'h0030);
    sw_read(1'b0, rd); check(rd == 16'h0000, "R11 both cleared", rd, 0);

    finish_run();
  end
endmodule